// File: doc/BRIEF.md
# Flash Reset and Ready/Busy Sequencer

This block follows the operating state of a flash device: idle (read or standby), program running, erase running and erase suspended. It drives the open-drain ready/busy line, filters the hardware reset pin, and decides whether each command arriving from the host interface is taken or refused.

The embedded program/erase controller tells the block when an operation starts, finishes, is suspended or is resumed. The block passes or refuses each host command from its current state. When the reset pin is held low long enough to count as a real reset, the block aborts any program or erase in progress and then times a recovery period. That period is short if the reset hit an idle device. It is long, with ready/busy held low the whole time, if the reset hit a program, an erase or a suspended erase.

Commands are plain control signals with no back-pressure. When `cmd_valid` is high, exactly one of `cmd_accept` or `cmd_reject` answers in the same cycle.

Top module: `flash_rst_rdy_seq`

## Requirements
- R1: After system reset the block is idle: `rb_drive_low` is 0, `rst_done` and `data_corrupt` are 0, and a program command is accepted.
- R2: `rb_drive_low` is 1 from the cycle after a program or erase start event until the cycle after the matching finish event. It is 0 while an erase is suspended.
- R3: Command op codes are 0 program, 1 erase, 2 suspend and 3 resume. Idle accepts program and erase. A running program accepts nothing. A running erase accepts only suspend. A suspended erase accepts only resume. Every other valid command is rejected.
- R4: A reset is recognised only when the synchronised pin stays low for at least MIN_PULSE consecutive cycles. A shorter low pulse leaves the state, `rb_drive_low` and command gating unchanged.
- R5: A reset that hits an idle device never pulls `rb_drive_low`. `rst_done` pulses SHORT_REC + SYNC_STAGES + 1 cycles after the pin rises.
- R6: A reset that hits a program, an erase or a suspended erase holds `rb_drive_low` at 1 until the cycle in which `rst_done` pulses. That cycle is LONG_REC + SYNC_STAGES + 1 cycles after the pin rises.
- R7: A reset that hits a program, an erase or a suspended erase gives a single one-cycle `data_corrupt` pulse, MIN_PULSE + SYNC_STAGES cycles after the pin falls. A reset from idle gives none. A stale finish event after the abort has no effect.
- R8: `rst_done` lasts exactly one cycle. In that cycle and after it the block is idle and ready.
- R9: A reset recognised during recovery restarts the recovery, keeps the long or short choice already made, and gives no new `data_corrupt` pulse.
- R10: While the reset pin holds the block and during recovery, every command is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| reset_pin_n | input | 1 | Hardware reset pin, active low, asynchronous to clk |
| pe_start_prog | input | 1 | Program operation started (one-cycle event) |
| pe_start_erase | input | 1 | Erase operation started (one-cycle event) |
| pe_done | input | 1 | Program or erase finished (one-cycle event) |
| pe_suspended | input | 1 | Erase entered suspend (one-cycle event) |
| pe_resumed | input | 1 | Suspended erase resumed (one-cycle event) |
| cmd_valid | input | 1 | A host command is presented this cycle |
| cmd_op | input | 2 | Command code: 0 program, 1 erase, 2 suspend, 3 resume |
| cmd_accept | output | 1 | Presented command is accepted |
| cmd_reject | output | 1 | Presented command is refused |
| rb_drive_low | output | 1 | 1 pulls the open-drain ready/busy line low; 0 releases it |
| rst_done | output | 1 | One-cycle pulse at the end of reset recovery |
| data_corrupt | output | 1 | One-cycle pulse when a reset aborts an active operation |

## Verification
Several properties are checked on every cycle. A busy line always refuses program and erase, and every command is refused during reset hold and recovery. The line is released only through a finish event, a suspend or the end of a reset. `rst_done` is a single cycle, the width filter fires at most once per low run, and the recovery counter stays below its limit. Only the bench's scenarios can show the exact cycle counts: pulse filter width, the short and long recovery lengths, and when the corrupt pulse appears. They also show that a restarted recovery keeps its long choice and that a pulse one cycle too short leaves a running program untouched.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_ESUSP = 3'd3,
    ST_RHOLD = 3'd4,
    ST_RECOV = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_PROGRAM = 2'd0,
    OP_ERASE   = 2'd1,
    OP_SUSPEND = 2'd2,
    OP_RESUME  = 2'd3
  } cmd_op_e;

  function automatic logic op_active(seq_state_e s);
    return (s == ST_PROG) || (s == ST_ERASE) || (s == ST_ESUSP);
  endfunction

  function automatic logic in_reset(seq_state_e s);
    return (s == ST_RHOLD) || (s == ST_RECOV);
  endfunction

endpackage

// File: rtl/rst_pulse_filter.sv
module rst_pulse_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_low,
  output logic hit
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b1;
        else        sync_q[0] <= pin_n;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign pin_low = ~sync_q[SYNC_STAGES-1];

  // length of the current low run, saturating one past the threshold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      run_q <= '0;
    else if (!pin_low)               run_q <= '0;
    else if (run_q != CW'(MIN_PULSE)) run_q <= run_q + 1'b1;
  end

  assign hit = pin_low && (run_q == CW'(MIN_PULSE - 1));

  // R4: one recognition per low run
  a_r4_hit_once: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

endmodule

// File: rtl/recov_timer.sv
module recov_timer #(
  parameter int SHORT_REC = 16,
  parameter int LONG_REC  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel_long,
  output logic hit
);
  localparam int LIM = (LONG_REC > SHORT_REC) ? LONG_REC : SHORT_REC;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = sel_long ? CW'(LONG_REC) : CW'(SHORT_REC);
  assign hit = run && (cnt_q == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (!hit) cnt_q <= cnt_q + 1'b1;
  end

  // R5 / R6: recovery count never passes the selected length
  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < lim));

endmodule

// File: rtl/cmd_gate.sv
module cmd_gate
  import flash_seq_pkg::*;
(
  input  seq_state_e state,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       cmd_accept,
  output logic       cmd_reject
);
  logic ok;

  always_comb begin
    ok = 1'b0;
    case (state)
      ST_IDLE:  ok = (cmd_op == OP_PROGRAM) || (cmd_op == OP_ERASE);
      ST_ERASE: ok = (cmd_op == OP_SUSPEND);
      ST_ESUSP: ok = (cmd_op == OP_RESUME);
      default:  ok = 1'b0;
    endcase
  end

  assign cmd_accept = cmd_valid && ok;
  assign cmd_reject = cmd_valid && !ok;

endmodule

// File: rtl/flash_rst_rdy_seq.sv
module flash_rst_rdy_seq
  import flash_seq_pkg::*;
#(
  parameter int MIN_PULSE   = 8,
  parameter int SHORT_REC   = 16,
  parameter int LONG_REC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reset_pin_n,
  input  logic       pe_start_prog,
  input  logic       pe_start_erase,
  input  logic       pe_done,
  input  logic       pe_suspended,
  input  logic       pe_resumed,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       cmd_accept,
  output logic       cmd_reject,
  output logic       rb_drive_low,
  output logic       rst_done,
  output logic       data_corrupt
);

  seq_state_e state_q, state_d;
  logic       long_q, long_d;
  logic       done_q, done_d;
  logic       corrupt_q, corrupt_d;
  logic       pin_low, rst_hit, tmr_hit;

  rst_pulse_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_PULSE(MIN_PULSE)) u_filter (
    .clk(clk), .rst_n(rst_n), .pin_n(reset_pin_n), .pin_low(pin_low), .hit(rst_hit)
  );

  recov_timer #(.SHORT_REC(SHORT_REC), .LONG_REC(LONG_REC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_RECOV), .sel_long(long_q), .hit(tmr_hit)
  );

  cmd_gate u_gate (
    .state(state_q), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
  );

  always_comb begin
    state_d   = state_q;
    long_d    = long_q;
    done_d    = 1'b0;
    corrupt_d = 1'b0;
    if (rst_hit) begin
      state_d   = ST_RHOLD;
      corrupt_d = op_active(state_q);
      if (op_active(state_q))      long_d = 1'b1;
      else if (!in_reset(state_q)) long_d = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (pe_start_prog)       state_d = ST_PROG;
          else if (pe_start_erase) state_d = ST_ERASE;
        end
        ST_PROG:  if (pe_done) state_d = ST_IDLE;
        ST_ERASE: begin
          if (pe_done)           state_d = ST_IDLE;
          else if (pe_suspended) state_d = ST_ESUSP;
        end
        ST_ESUSP: if (pe_resumed) state_d = ST_ERASE;
        ST_RHOLD: if (!pin_low)   state_d = ST_RECOV;
        ST_RECOV: begin
          if (tmr_hit) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      long_q    <= 1'b0;
      done_q    <= 1'b0;
      corrupt_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      long_q    <= long_d;
      done_q    <= done_d;
      corrupt_q <= corrupt_d;
    end
  end

  assign rb_drive_low = (state_q == ST_PROG) || (state_q == ST_ERASE) ||
                        (in_reset(state_q) && long_q);
  assign rst_done     = done_q;
  assign data_corrupt = corrupt_q;

  // R2: a busy line never lets program or erase through
  a_r2_busy_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_drive_low && cmd_valid && (cmd_op == OP_PROGRAM || cmd_op == OP_ERASE)) |-> !cmd_accept);

  // R10: nothing accepted while reset holds or recovers
  a_r10_reset_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset(state_q) |-> !cmd_accept);

  // R8: completion pulse is one cycle wide
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |=> !rst_done);

  // R8: at completion the block is idle and ready
  a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |-> (!rb_drive_low && state_q == ST_IDLE));

  // R7: abort flag only on entry to the long hold
  a_r7_corrupt_enters_hold: assert property (@(posedge clk) disable iff (!rst_n)
    data_corrupt |-> (state_q == ST_RHOLD && rb_drive_low));

  // R6: the line is released only by a finish, a suspend or reset completion
  a_r6_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_drive_low) |-> (rst_done || $past(pe_done) || $past(pe_suspended)));

endmodule

// File: tb/tb_flash_rst_rdy_seq.sv
module tb_flash_rst_rdy_seq;
  import flash_seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_W  = 4;
  localparam int SHORT_T = 6;
  localparam int LONG_T  = 20;
  localparam int SYNC_N  = 2;
  localparam int K_DONE = 0;
  localparam int K_CORR = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_pin_n = 1'b1;
  logic pe_start_prog = 1'b0, pe_start_erase = 1'b0, pe_done = 1'b0;
  logic pe_suspended = 1'b0, pe_resumed = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_accept, cmd_reject, rb_drive_low, rst_done, data_corrupt;

  flash_rst_rdy_seq #(.MIN_PULSE(MIN_W), .SHORT_REC(SHORT_T), .LONG_REC(LONG_T),
                      .SYNC_STAGES(SYNC_N)) dut (
    .clk(clk), .rst_n(rst_n), .reset_pin_n(reset_pin_n),
    .pe_start_prog(pe_start_prog), .pe_start_erase(pe_start_erase), .pe_done(pe_done),
    .pe_suspended(pe_suspended), .pe_resumed(pe_resumed),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
    .rb_drive_low(rb_drive_low), .rst_done(rst_done), .data_corrupt(data_corrupt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;

  typedef struct { int kind; int at; string req; } exp_t;
  exp_t expq[$];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push_exp(int kind, int at, string req);
    exp_t e;
    e.kind = kind; e.at = at; e.req = req;
    expq.push_back(e);
  endtask

  task automatic pop_cmp(int kind);
    exp_t e;
    if (expq.size() == 0) begin
      chk(kind == K_DONE ? "R8 unexpected rst_done" : "R7 unexpected data_corrupt", 1, 0);
    end else begin
      e = expq.pop_front();
      chk({e.req, " pulse kind"}, kind, e.kind);
      chk({e.req, " pulse cycle"}, cyc, e.at);
    end
  endtask

  // monitor: pops expected pulses as the design produces them
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk("R8 rst_done one cycle", int'(rst_done), 0);
      if (data_corrupt) pop_cmp(K_CORR);
      if (rst_done)     pop_cmp(K_DONE);
      prev_done = rst_done;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pe_event(int which);
    case (which)
      0: pe_start_prog  = 1'b1;
      1: pe_start_erase = 1'b1;
      2: pe_done        = 1'b1;
      3: pe_suspended   = 1'b1;
      default: pe_resumed = 1'b1;
    endcase
    tick(1);
    pe_start_prog = 1'b0; pe_start_erase = 1'b0; pe_done = 1'b0;
    pe_suspended = 1'b0; pe_resumed = 1'b0;
    tick(1);
  endtask

  task automatic probe(string req, logic [1:0] op, int exp_acc);
    cmd_valid = 1'b1;
    cmd_op = op;
    #1;
    chk({req, " accept"}, int'(cmd_accept), exp_acc);
    chk({req, " reject"}, int'(cmd_reject), 1 - exp_acc);
    cmd_valid = 1'b0;
  endtask

  // drives a low pulse; returns the cycle at which the pin was raised
  task automatic reset_pulse(int low_n, int corrupt, output int raised_at);
    int c0;
    c0 = cyc;
    reset_pin_n = 1'b0;
    if (corrupt != 0) push_exp(K_CORR, c0 + MIN_W + SYNC_N, "R7 abort flag");
    tick(low_n);
    reset_pin_n = 1'b1;
    raised_at = cyc;
  endtask

  int c1;
  int c3;

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    chk("R1 rb released after reset", int'(rb_drive_low), 0);
    chk("R1 no done after reset", int'(rst_done), 0);
    chk("R1 no corrupt after reset", int'(data_corrupt), 0);
    probe("R1 program accepted at idle", OP_PROGRAM, 1);

    // R3 idle gating
    probe("R3 idle erase", OP_ERASE, 1);
    probe("R3 idle suspend", OP_SUSPEND, 0);
    probe("R3 idle resume", OP_RESUME, 0);

    // R2 / R3 program
    pe_event(0);
    chk("R2 busy during program", int'(rb_drive_low), 1);
    probe("R3 program blocks program", OP_PROGRAM, 0);
    probe("R3 program blocks erase", OP_ERASE, 0);
    probe("R3 program blocks suspend", OP_SUSPEND, 0);
    pe_event(2);
    chk("R2 ready after program", int'(rb_drive_low), 0);

    // R2 / R3 erase, suspend, resume
    pe_event(1);
    chk("R2 busy during erase", int'(rb_drive_low), 1);
    probe("R3 erase allows suspend", OP_SUSPEND, 1);
    probe("R3 erase blocks program", OP_PROGRAM, 0);
    pe_event(3);
    chk("R2 ready in erase suspend", int'(rb_drive_low), 0);
    probe("R3 suspend allows resume", OP_RESUME, 1);
    probe("R3 suspend blocks program", OP_PROGRAM, 0);
    pe_event(4);
    chk("R2 busy after resume", int'(rb_drive_low), 1);
    pe_event(2);
    chk("R2 ready after erase", int'(rb_drive_low), 0);

    // R4 short pulse at idle is ignored
    reset_pulse(MIN_W - 1, 0, c1);
    tick(LONG_T);
    chk("R4 short pulse idle rb", int'(rb_drive_low), 0);
    probe("R4 short pulse idle gating", OP_PROGRAM, 1);

    // R4 short pulse during program leaves it running
    pe_event(0);
    reset_pulse(MIN_W - 1, 0, c1);
    tick(6);
    chk("R4 program survives short pulse", int'(rb_drive_low), 1);
    probe("R4 program gating unchanged", OP_ERASE, 0);
    pe_event(2);
    chk("R4 program finishes normally", int'(rb_drive_low), 0);

    // R5 / R10 reset from idle, short recovery
    begin
      int c0;
      c0 = cyc;
      reset_pin_n = 1'b0;
      wait_to(c0 + MIN_W + SYNC_N + 1);
      chk("R5 idle reset leaves rb released", int'(rb_drive_low), 0);
      probe("R10 reject while pin holds", OP_PROGRAM, 0);
      tick(3);
      reset_pin_n = 1'b1;
      c1 = cyc;
      push_exp(K_DONE, c1 + SHORT_T + SYNC_N + 1, "R5 short recovery");
      tick(SYNC_N + 2);
      probe("R10 reject during recovery", OP_ERASE, 0);
      chk("R5 rb released in recovery", int'(rb_drive_low), 0);
      wait_to(c1 + SHORT_T + SYNC_N + 3);
      probe("R8 idle after short recovery", OP_PROGRAM, 1);
    end

    // R6 / R7 reset during program, long recovery
    pe_event(0);
    reset_pulse(MIN_W + 2, 1, c1);
    push_exp(K_DONE, c1 + LONG_T + SYNC_N + 1, "R6 long recovery");
    chk("R6 busy while reset holds", int'(rb_drive_low), 1);
    wait_to(c1 + LONG_T + SYNC_N);
    chk("R6 busy one cycle before done", int'(rb_drive_low), 1);
    tick(1);
    chk("R6 released at done", int'(rb_drive_low), 0);
    tick(2);
    probe("R8 idle after long recovery", OP_PROGRAM, 1);
    pe_event(2);
    chk("R7 stale finish ignored", int'(rb_drive_low), 0);
    probe("R7 idle gating after stale finish", OP_ERASE, 1);

    // R6 / R7 reset during erase suspend
    pe_event(1);
    pe_event(3);
    chk("R2 suspend releases before reset", int'(rb_drive_low), 0);
    reset_pulse(MIN_W, 1, c1);
    push_exp(K_DONE, c1 + LONG_T + SYNC_N + 1, "R6 long recovery from suspend");
    tick(SYNC_N + 1);
    chk("R6 suspend reset pulls line", int'(rb_drive_low), 1);
    wait_to(c1 + LONG_T + SYNC_N + 3);
    probe("R8 idle after suspend reset", OP_RESUME, 0);

    // R9 reset again during a long recovery
    pe_event(1);
    reset_pulse(MIN_W + 2, 1, c1);
    tick(5);
    reset_pulse(MIN_W + 2, 0, c3);
    push_exp(K_DONE, c3 + LONG_T + SYNC_N + 1, "R9 restarted recovery");
    wait_to(c3 + LONG_T + SYNC_N);
    chk("R9 long choice kept", int'(rb_drive_low), 1);
    tick(3);
    chk("R9 ready after restart", int'(rb_drive_low), 0);

    tick(5);
    chk("R7 all expected pulses seen", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc == 50000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule